// File: doc/BRIEF.md
# Multi-Wide In-Order Retirement Buffer

This block keeps the program order of instructions that execute out of order. At dispatch a group of up to four instructions enters a circular buffer. Each one receives the index of its slot, and that index travels down the pipeline with it. Execution units later report completion by that index, and may attach a nonzero exception code. Every cycle the block examines the four oldest slots and chooses which of them leave the machine. For each leaving instruction it presents the logical destination, the newly assigned physical register, the physical register that mapping replaced, the PC, the type and the exception code.

Dispatch is a valid/ready stream with a count. A group is taken on a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` depends on `disp_num` within the same cycle: it is high only when the buffer has at least `disp_num` free slots. A group is never split. If it does not fit, dispatch must hold it and its contents. Retirement has no back-pressure. A lane flagged in `ret_valid` has left the buffer at the next clock edge. Completion writebacks and the flush are plain control inputs.

Top module: `rob_retire`

## Requirements
- R1: After reset the buffer reports empty and not full, no retire lane is valid, and a dispatch group of four is accepted.
- R2: An accepted group of n takes the n slots that follow the previous allocation, modulo the depth. Lane i of `disp_idx` gives the slot for lane i, and the first slot after reset or flush is 0.
- R3: When fewer slots are free than `disp_num` requests, `disp_ready` is low and nothing is allocated, so `disp_idx` does not move. `rob_full` is high when every slot holds an instruction.
- R4: A writeback marks its slot complete at the clock edge. An instruction retires only from the head of the buffer and only once complete, and its retire lane is valid in the cycle after the writeback edge.
- R5: An incomplete instruction blocks itself and every younger instruction from retiring, even when the younger ones are complete.
- R6: Up to four instructions retire per cycle, oldest on lane 0. The valid lanes always form a run that starts at lane 0.
- R7: At most one instruction of type 1 (branch) retires per cycle. A second branch among the candidates waits for the next cycle.
- R8: A nonzero exception code marks an exception. The oldest retiring instruction that carries one retires with its code on `ret_exc`, and every younger instruction is held back that cycle.
- R9: A flush empties the buffer at the next edge and restarts allocation at slot 0. Writebacks that arrive on the flush cycle, or that name an unallocated slot, have no effect.
- R10: The retire lanes carry the destination, new mapping, old mapping, PC and type that were given at dispatch.
- R11: The pointers keep a wrap bit, so a buffer that wrapped and then filled reads full and not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard every in-flight instruction |
| disp_valid | input | 1 | Dispatch group offered |
| disp_ready | output | 1 | Enough free slots for `disp_num` |
| disp_num | input | CNT_W | Number of lanes in the group (0..WIDTH) |
| disp_areg | input | WIDTH x AREG_W | Logical destination per lane |
| disp_preg | input | WIDTH x PREG_W | New physical destination per lane |
| disp_opreg | input | WIDTH x PREG_W | Previous physical mapping per lane |
| disp_pc | input | WIDTH x PC_W | PC per lane |
| disp_type | input | WIDTH x 2 | Type: 0 ALU, 1 branch, 2 store, 3 other |
| disp_idx | output | WIDTH x IDX_W | Slot assigned to each lane |
| wb_valid | input | WIDTH | Writeback strobe per port |
| wb_idx | input | WIDTH x IDX_W | Slot completed by each port |
| wb_exc | input | WIDTH x EXC_W | Exception code, 0 for none |
| ret_valid | output | WIDTH | Lane retires this cycle |
| ret_areg | output | WIDTH x AREG_W | Retiring logical destination |
| ret_preg | output | WIDTH x PREG_W | Retiring new mapping |
| ret_opreg | output | WIDTH x PREG_W | Retiring old mapping |
| ret_pc | output | WIDTH x PC_W | Retiring PC |
| ret_type | output | WIDTH x 2 | Retiring type |
| ret_exc | output | WIDTH x EXC_W | Retiring exception code |
| rob_empty | output | 1 | No instruction held |
| rob_full | output | 1 | All slots held |

## Verification
The bench makes the head entry the last to complete. A design that retired out of order would let the younger entries leave early. It offers groups that hold two branches, and a group with an exception in the middle. A wrong selector would let both branches go, or would let instructions younger than the exception slip out. It fills the buffer across the wrap point and then checks that a too-large group is refused whole. A design without the wrap bit would call the full buffer empty or overwrite live slots. Last, it sends writebacks on the flush cycle and to a slot that is no longer allocated. A design that obeyed them would later retire a fresh instruction that never completed.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam logic [1:0] KIND_ALU    = 2'd0;
  localparam logic [1:0] KIND_BRANCH = 2'd1;
  localparam logic [1:0] KIND_STORE  = 2'd2;
  localparam logic [1:0] KIND_OTHER  = 2'd3;
endpackage

// File: rtl/rob_alloc_ctrl.sv
// Head/tail pointers with a wrap bit, occupancy and dispatch acceptance.
module rob_alloc_ctrl #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  localparam int PTR_W = $clog2(DEPTH) + 1,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             disp_valid,
  input  logic [CNT_W-1:0] disp_num,
  input  logic [CNT_W-1:0] ret_num,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [PTR_W-1:0] count,
  output logic             disp_ready,
  output logic             disp_fire,
  output logic             rob_empty,
  output logic             rob_full
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [PTR_W-1:0] free_slots;

  assign count      = tail - head;
  assign free_slots = DEPTH_P - count;
  assign disp_ready = (int'(disp_num) <= WIDTH) && (int'(disp_num) <= int'(free_slots));
  assign disp_fire  = disp_valid && disp_ready;
  assign rob_empty  = (count == '0);
  assign rob_full   = (count == DEPTH_P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (flush) begin
      head <= '0;
      tail <= '0;
    end else begin
      head <= head + PTR_W'(ret_num);
      if (disp_fire) tail <= tail + PTR_W'(disp_num);
    end
  end
endmodule

// File: rtl/rob_retire_pick.sv
// Chooses the retiring run among the oldest WIDTH candidates.
module rob_retire_pick #(
  parameter int WIDTH = 4,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] cand_ok,
  input  logic [WIDTH-1:0] cand_br,
  input  logic [WIDTH-1:0] cand_exc,
  output logic [WIDTH-1:0] ret_mask,
  output logic [CNT_W-1:0] ret_num
);
  always_comb begin
    logic run, br_seen, exc_seen, take;
    run      = 1'b1;
    br_seen  = 1'b0;
    exc_seen = 1'b0;
    ret_mask = '0;
    ret_num  = '0;
    for (int i = 0; i < WIDTH; i++) begin
      take = run && cand_ok[i] && !exc_seen && !(br_seen && cand_br[i]);
      ret_mask[i] = take;
      if (!take) run = 1'b0;
      br_seen  = br_seen  | (take & cand_br[i]);
      exc_seen = exc_seen | (take & cand_exc[i]);
      ret_num  = ret_num + CNT_W'(take);
    end
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 4,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  parameter int PC_W   = 32,
  parameter int EXC_W  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          disp_valid,
  output logic                          disp_ready,
  input  logic [CNT_W-1:0]              disp_num,
  input  logic [WIDTH-1:0][AREG_W-1:0]  disp_areg,
  input  logic [WIDTH-1:0][PREG_W-1:0]  disp_preg,
  input  logic [WIDTH-1:0][PREG_W-1:0]  disp_opreg,
  input  logic [WIDTH-1:0][PC_W-1:0]    disp_pc,
  input  logic [WIDTH-1:0][1:0]         disp_type,
  output logic [WIDTH-1:0][IDX_W-1:0]   disp_idx,
  input  logic [WIDTH-1:0]              wb_valid,
  input  logic [WIDTH-1:0][IDX_W-1:0]   wb_idx,
  input  logic [WIDTH-1:0][EXC_W-1:0]   wb_exc,
  output logic [WIDTH-1:0]              ret_valid,
  output logic [WIDTH-1:0][AREG_W-1:0]  ret_areg,
  output logic [WIDTH-1:0][PREG_W-1:0]  ret_preg,
  output logic [WIDTH-1:0][PREG_W-1:0]  ret_opreg,
  output logic [WIDTH-1:0][PC_W-1:0]    ret_pc,
  output logic [WIDTH-1:0][1:0]         ret_type,
  output logic [WIDTH-1:0][EXC_W-1:0]   ret_exc,
  output logic                          rob_empty,
  output logic                          rob_full
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head, tail, count;
  logic             disp_fire;
  logic [CNT_W-1:0] ret_num;
  logic [WIDTH-1:0] ret_mask;

  // entry state
  logic [DEPTH-1:0]  ent_live;
  logic [DEPTH-1:0]  ent_done;
  logic [AREG_W-1:0] ent_areg  [DEPTH];
  logic [PREG_W-1:0] ent_preg  [DEPTH];
  logic [PREG_W-1:0] ent_opreg [DEPTH];
  logic [PC_W-1:0]   ent_pc    [DEPTH];
  logic [1:0]        ent_kind  [DEPTH];
  logic [EXC_W-1:0]  ent_exc   [DEPTH];

  logic [WIDTH-1:0][IDX_W-1:0] head_slot;
  logic [WIDTH-1:0]            cand_ok, cand_br, cand_exc;
  logic [WIDTH-1:0]            lane_alloc;

  rob_alloc_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .disp_valid (disp_valid),
    .disp_num   (disp_num),
    .ret_num    (ret_num),
    .head       (head),
    .tail       (tail),
    .count      (count),
    .disp_ready (disp_ready),
    .disp_fire  (disp_fire),
    .rob_empty  (rob_empty),
    .rob_full   (rob_full)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign disp_idx[i]   = tail[IDX_W-1:0] + IDX_W'(i);
    assign lane_alloc[i] = disp_fire && (i < int'(disp_num));
    assign head_slot[i]  = head[IDX_W-1:0] + IDX_W'(i);
    assign cand_ok[i]    = (PTR_W'(i) < count) && ent_live[head_slot[i]] && ent_done[head_slot[i]];
    assign cand_br[i]    = (ent_kind[head_slot[i]] == KIND_BRANCH);
    assign cand_exc[i]   = (ent_exc[head_slot[i]] != '0);
    assign ret_areg[i]   = ent_areg[head_slot[i]];
    assign ret_preg[i]   = ent_preg[head_slot[i]];
    assign ret_opreg[i]  = ent_opreg[head_slot[i]];
    assign ret_pc[i]     = ent_pc[head_slot[i]];
    assign ret_type[i]   = ent_kind[head_slot[i]];
    assign ret_exc[i]    = ent_exc[head_slot[i]];
  end

  rob_retire_pick #(.WIDTH(WIDTH)) u_pick (
    .cand_ok  (cand_ok),
    .cand_br  (cand_br),
    .cand_exc (cand_exc),
    .ret_mask (ret_mask),
    .ret_num  (ret_num)
  );

  assign ret_valid = ret_mask;

  // live and complete flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_live <= '0;
      ent_done <= '0;
    end else if (flush) begin
      ent_live <= '0;
    end else begin
      for (int i = 0; i < WIDTH; i++)
        if (ret_mask[i]) ent_live[head_slot[i]] <= 1'b0;
      for (int i = 0; i < WIDTH; i++)
        if (lane_alloc[i]) begin
          ent_live[disp_idx[i]] <= 1'b1;
          ent_done[disp_idx[i]] <= 1'b0;
        end
      for (int k = 0; k < WIDTH; k++)
        if (wb_valid[k] && ent_live[wb_idx[k]]) ent_done[wb_idx[k]] <= 1'b1;
    end
  end

  // payload, no reset needed
  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int i = 0; i < WIDTH; i++)
        if (lane_alloc[i]) begin
          ent_areg[disp_idx[i]]  <= disp_areg[i];
          ent_preg[disp_idx[i]]  <= disp_preg[i];
          ent_opreg[disp_idx[i]] <= disp_opreg[i];
          ent_pc[disp_idx[i]]    <= disp_pc[i];
          ent_kind[disp_idx[i]]  <= disp_type[i];
          ent_exc[disp_idx[i]]   <= '0;
        end
      for (int k = 0; k < WIDTH; k++)
        if (wb_valid[k] && ent_live[wb_idx[k]]) ent_exc[wb_idx[k]] <= wb_exc[k];
    end
  end
endmodule

// File: rtl/rob_retire_chk.sv
module rob_retire_chk #(
  parameter int WIDTH = 4,
  parameter int EXC_W = 4,
  parameter int CNT_W = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        flush,
  input logic                        disp_ready,
  input logic [CNT_W-1:0]            disp_num,
  input logic [WIDTH-1:0]            ret_valid,
  input logic [WIDTH-1:0][1:0]       ret_type,
  input logic [WIDTH-1:0][EXC_W-1:0] ret_exc,
  input logic                        rob_empty,
  input logic                        rob_full
);
  logic [WIDTH-1:0] br_ret, exc_ret;
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      br_ret[i]  = ret_valid[i] && (ret_type[i] == 2'd1);
      exc_ret[i] = ret_valid[i] && (ret_exc[i] != '0);
    end
  end

  assert_quiet_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty |-> (ret_valid == '0));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_full && disp_num != '0) |-> !disp_ready);
  assert_run_from_lane0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_valid + 1'b1) & ret_valid) == '0);
  assert_one_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(br_ret) <= 1);
  assert_one_exception_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc_ret));
  assert_exc_is_youngest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret != '0) |-> ((ret_valid & ~(exc_ret | (exc_ret - 1'b1))) == '0));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rob_empty && ret_valid == '0));
  assert_full_not_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rob_full && rob_empty));
endmodule

bind rob_retire rob_retire_chk #(.WIDTH(WIDTH), .EXC_W(EXC_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .disp_ready (disp_ready),
  .disp_num   (disp_num),
  .ret_valid  (ret_valid),
  .ret_type   (ret_type),
  .ret_exc    (ret_exc),
  .rob_empty  (rob_empty),
  .rob_full   (rob_full)
);

// File: tb/sim_rob_retire.sv
module sim_rob_retire;
  localparam int DEPTH = 16, WIDTH = 4, AREG_W = 5, PREG_W = 7, PC_W = 32, EXC_W = 4;
  localparam int IDX_W = 4, CNT_W = 3;
  localparam logic [1:0] K_ALU = 2'd0, K_BR = 2'd1;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [CNT_W-1:0] disp_num = '0;
  logic [WIDTH-1:0][AREG_W-1:0] disp_areg = '0;
  logic [WIDTH-1:0][PREG_W-1:0] disp_preg = '0, disp_opreg = '0;
  logic [WIDTH-1:0][PC_W-1:0]   disp_pc = '0;
  logic [WIDTH-1:0][1:0]        disp_type = '0;
  logic [WIDTH-1:0][IDX_W-1:0]  disp_idx;
  logic [WIDTH-1:0]             wb_valid = '0;
  logic [WIDTH-1:0][IDX_W-1:0]  wb_idx = '0;
  logic [WIDTH-1:0][EXC_W-1:0]  wb_exc = '0;
  logic [WIDTH-1:0]             ret_valid;
  logic [WIDTH-1:0][AREG_W-1:0] ret_areg;
  logic [WIDTH-1:0][PREG_W-1:0] ret_preg, ret_opreg;
  logic [WIDTH-1:0][PC_W-1:0]   ret_pc;
  logic [WIDTH-1:0][1:0]        ret_type;
  logic [WIDTH-1:0][EXC_W-1:0]  ret_exc;
  logic rob_empty, rob_full;

  int n_chk = 0, n_fail = 0, seq = 0;
  bit finished = 1'b0;
  logic [AREG_W-1:0] e_areg [DEPTH];
  logic [PREG_W-1:0] e_preg [DEPTH], e_opreg [DEPTH];
  logic [PC_W-1:0]   e_pc [DEPTH];

  always #2 clk = ~clk;

  rob_retire u0 (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic dispatch(input int n, input logic [3:0][1:0] kinds, input int first);
    disp_valid = 1'b1;
    disp_num = CNT_W'(n);
    for (int l = 0; l < WIDTH; l++) begin
      disp_areg[l]  = AREG_W'(seq + l);
      disp_preg[l]  = PREG_W'(seq + l + 40);
      disp_opreg[l] = PREG_W'(seq + l + 3);
      disp_pc[l]    = 32'h1000 + 32'(4 * (seq + l));
      disp_type[l]  = kinds[l];
    end
    #1;
    check("R3", "ready for fitting group", disp_ready, 1);
    for (int l = 0; l < n; l++) begin
      check("R2", "disp_idx", disp_idx[l], (first + l) % DEPTH);
      e_areg[disp_idx[l]]  = disp_areg[l];
      e_preg[disp_idx[l]]  = disp_preg[l];
      e_opreg[disp_idx[l]] = disp_opreg[l];
      e_pc[disp_idx[l]]    = disp_pc[l];
    end
    seq += n;
    tick();
    disp_valid = 1'b0;
    disp_num = '0;
  endtask

  task automatic wback(input logic [3:0] mask, input logic [3:0][3:0] idx, input logic [3:0][3:0] exc);
    wb_valid = mask;
    wb_idx = idx;
    wb_exc = exc;
    tick();
    wb_valid = '0;
    #1;
  endtask

  task automatic t_reset();
    check("R1", "empty", rob_empty, 1);
    check("R1", "full", rob_full, 0);
    check("R1", "ret_valid", ret_valid, 0);
    disp_num = 3'd4;
    #1;
    check("R1", "ready for four", disp_ready, 1);
    disp_num = '0;
  endtask

  task automatic t_order();
    dispatch(4, {K_ALU, K_ALU, K_ALU, K_ALU}, 0);
    dispatch(3, {K_ALU, K_ALU, K_ALU, K_ALU}, 4);
    wback(4'b0011, {4'd0, 4'd0, 4'd2, 4'd1}, '0);
    check("R5", "head incomplete blocks younger", ret_valid, 0);
    wback(4'b0001, {4'd0, 4'd0, 4'd0, 4'd0}, '0);
    check("R4", "retire after head completes", ret_valid, 4'b0111);
    for (int l = 0; l < 3; l++) begin
      check("R10", "ret_pc", ret_pc[l], e_pc[l]);
      check("R10", "ret_areg", ret_areg[l], e_areg[l]);
      check("R10", "ret_preg", ret_preg[l], e_preg[l]);
      check("R10", "ret_opreg", ret_opreg[l], e_opreg[l]);
    end
  endtask

  task automatic t_wide();
    wback(4'b1111, {4'd6, 4'd5, 4'd4, 4'd3}, '0);
    check("R6", "four retire together", ret_valid, 4'b1111);
    check("R10", "ret_pc lane3", ret_pc[3], e_pc[6]);
  endtask

  task automatic t_branch();
    dispatch(4, {K_ALU, K_BR, K_ALU, K_BR}, 7);
    wback(4'b1111, {4'd10, 4'd9, 4'd8, 4'd7}, '0);
    check("R7", "second branch held", ret_valid, 4'b0011);
    check("R10", "ret_type lane0", ret_type[0], K_BR);
    tick();
    check("R7", "held branch next cycle", ret_valid, 4'b0011);
    check("R7", "held branch type", ret_type[0], K_BR);
    tick();
    check("R7", "drained", rob_empty, 1);
  endtask

  task automatic t_exception();
    dispatch(4, {K_ALU, K_ALU, K_ALU, K_ALU}, 11);
    wback(4'b1111, {4'd14, 4'd13, 4'd12, 4'd11}, {4'd0, 4'd0, 4'd5, 4'd0});
    check("R8", "cut after exception", ret_valid, 4'b0011);
    check("R8", "exception code", ret_exc[1], 5);
    check("R8", "older lane clean", ret_exc[0], 0);
    tick();
    check("R8", "younger retire next", ret_valid, 4'b0011);
    check("R8", "no code on younger", ret_exc[0], 0);
    tick();
    check("R8", "drained", rob_empty, 1);
  endtask

  task automatic t_full();
    dispatch(4, {K_ALU, K_ALU, K_ALU, K_ALU}, 15);
    dispatch(4, {K_ALU, K_ALU, K_ALU, K_ALU}, 3);
    dispatch(4, {K_ALU, K_ALU, K_ALU, K_ALU}, 7);
    dispatch(2, {K_ALU, K_ALU, K_ALU, K_ALU}, 11);
    disp_num = 3'd3;
    #1;
    check("R3", "group of 3 with 2 free", disp_ready, 0);
    disp_num = 3'd2;
    #1;
    check("R3", "group of 2 with 2 free", disp_ready, 1);
    disp_num = '0;
    dispatch(2, {K_ALU, K_ALU, K_ALU, K_ALU}, 13);
    check("R3", "full", rob_full, 1);
    check("R11", "wrapped full not empty", rob_empty, 0);
    disp_valid = 1'b1;
    disp_num = 3'd1;
    #1;
    check("R3", "refused when full", disp_ready, 0);
    tick();
    disp_valid = 1'b0;
    disp_num = '0;
    #1;
    check("R3", "no allocation while full", disp_idx[0], 15);
    check("R3", "still full", rob_full, 1);
  endtask

  task automatic t_flush();
    flush = 1'b1;
    wb_valid = 4'b0001;
    wb_idx = {4'd0, 4'd0, 4'd0, 4'd15};
    tick();
    flush = 1'b0;
    wb_valid = '0;
    #1;
    check("R9", "empty after flush", rob_empty, 1);
    check("R9", "no retire after flush", ret_valid, 0);
    check("R9", "alloc restarts at 0", disp_idx[0], 0);
    wback(4'b0001, {4'd0, 4'd0, 4'd0, 4'd0}, '0);
    dispatch(1, {K_ALU, K_ALU, K_ALU, K_ALU}, 0);
    check("R9", "stale writeback ignored", ret_valid, 0);
    check("R9", "entry held", rob_empty, 0);
    wback(4'b0001, {4'd0, 4'd0, 4'd0, 4'd0}, '0);
    check("R4", "retire after real writeback", ret_valid, 4'b0001);
    check("R10", "ret_pc after flush", ret_pc[0], e_pc[0]);
    tick();
    check("R4", "empty after retire", rob_empty, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_wide();
    t_branch();
    t_exception();
    t_full();
    t_flush();
    finish_run();
  end
endmodule